// File: doc/BRIEF.md
# Pseudo-Random Sequence Bit-Error Analyser

This block checks a received test channel that carries a maximal-length pseudo-random bit sequence. It locks a local reference generator onto the incoming bits and then counts every bit that disagrees with the reference. The running total sits in an 8-bit counter that a processor reads. The read returns the current value and clears the counter.

Bits arrive one per cycle, qualified by a valid strobe, so the channel can run at any rate below the clock. To lock, the block first copies received bits straight into the reference register. It then lets the reference run on its own and requires an unbroken run of matching bits before it declares lock. While it is locked, each mismatch adds one to the counter. When the counter fills up, lock is dropped and acquisition starts again. A counter that stays at all ones therefore tells software that the link has lost lock.

Top module: `prbs_analyser`

## Requirements
- R1: After reset, `err_cnt_o` is 0x00 and `sync_lost_o` is 0.
- R2: While `ana_en_i` is 0, received bits are not counted and `err_cnt_o` keeps its value. A read still clears it.
- R3: While locked, each cycle with `rx_vld_i`=1 whose bit differs from the reference adds exactly one to `err_cnt_o` at that clock edge. Cycles with `rx_vld_i`=0 change nothing, whatever `rx_bit_i` holds.
- R4: Acquisition loads the first 15 valid bits into the reference. Lock is declared after the next 16 valid bits all match. A mismatch during those 16 bits restarts loading. No error is counted before lock.
- R5: A cycle with `rd_clr_i`=1 sets `err_cnt_o` to 0 at that edge, unless R7 applies.
- R6: The counter saturates at 0xFF and never wraps. `sync_lost_o` is 1 exactly when `err_cnt_o` is 0xFF.
- R7: A read and a counted error in the same cycle leave `err_cnt_o` at 1.
- R8: When a counted error leaves the counter at 0xFF, lock is dropped and acquisition (R4) restarts with the next valid bit.
- R9: Setting `ana_en_i` to 0 drops lock. After it is set back to 1, a full acquisition is needed before errors are counted again.
- R10: The reference follows x^15 + x^14 + 1. Each expected bit is the XOR of the bits 14 and 15 positions earlier in the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ana_en_i | input | 1 | Analyser enable |
| rx_bit_i | input | 1 | Received sequence bit |
| rx_vld_i | input | 1 | Strobe marking `rx_bit_i` valid |
| rd_clr_i | input | 1 | Processor read of the counter (clears it) |
| err_cnt_o | output | 8 | Error count |
| sync_lost_o | output | 1 | Counter saturated, lock lost |

## Verification
The bench builds the block with its default parameters: a 15-bit reference, a 16-bit confirmation run and an 8-bit counter. With these values, saturation at 0xFF takes only a few hundred cycles of injected errors. This lets the bench cover the no-wrap hold, the drop of lock and a complete re-acquisition followed by fresh counting. The short confirmation window also lets the bench place a deliberate mismatch inside it, and place one just after re-enable, to show that lock is not carried over.

// File: rtl/prbs_ana_pkg.sv
package prbs_ana_pkg;
  typedef enum logic [1:0] {
    PA_HUNT    = 2'd0,
    PA_CONFIRM = 2'd1,
    PA_LOCK    = 2'd2
  } pa_state_e;
endpackage

// File: rtl/prbs_rst_sync.sv
module prbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen #(
  parameter int LFSR_W = 15,
  parameter int TAP_A  = 14,
  parameter int TAP_B  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic load_sel,
  input  logic bit_in,
  output logic pred_o
);
  logic [LFSR_W-1:0] sr_q, sr_d;
  logic              feed;

  // sr_q[0] holds the newest bit; position k-1 holds the bit k steps back
  assign pred_o = sr_q[TAP_A-1] ^ sr_q[TAP_B-1];
  assign feed   = load_sel ? bit_in : pred_o;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[LFSR_W-2:0], feed};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/prbs_sync_ctl.sv
module prbs_sync_ctl
  import prbs_ana_pkg::*;
#(
  parameter int LOAD_LEN = 15,
  parameter int CONF_LEN = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      bit_vld,
  input  logic      mismatch,
  input  logic      sat_drop,
  output pa_state_e state_o
);
  localparam int MAXLEN = (LOAD_LEN > CONF_LEN) ? LOAD_LEN : CONF_LEN;
  localparam int PH_W   = $clog2(MAXLEN + 1);

  pa_state_e        st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    if (!en) begin
      st_d = PA_HUNT;
      ph_d = '0;
    end else if (bit_vld) begin
      unique case (st_q)
        PA_HUNT: begin
          if (ph_q == PH_W'(LOAD_LEN - 1)) begin
            st_d = PA_CONFIRM;
            ph_d = '0;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        PA_CONFIRM: begin
          if (mismatch) begin
            st_d = PA_HUNT;
            ph_d = '0;
          end else if (ph_q == PH_W'(CONF_LEN - 1)) begin
            st_d = PA_LOCK;
            ph_d = '0;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        PA_LOCK: begin
          if (sat_drop) begin
            st_d = PA_HUNT;
            ph_d = '0;
          end
        end
        default: begin
          st_d = PA_HUNT;
          ph_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PA_HUNT;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/prbs_err_cnt.sv
module prbs_err_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_evt,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, base;

  always_comb begin
    base  = rd_clr ? '0 : cnt_q;
    cnt_d = base;
    if (err_evt && (base != CNT_MAX)) cnt_d = base + 1'b1;
  end

  assign sat_hit_o = err_evt && (cnt_d == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/prbs_analyser.sv
module prbs_analyser
  import prbs_ana_pkg::*;
#(
  parameter int LFSR_W   = 15,
  parameter int TAP_A    = 14,
  parameter int CONF_LEN = 16,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ana_en_i,
  input  logic             rx_bit_i,
  input  logic             rx_vld_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             sync_lost_o
);
  logic      rst_ns;
  logic      pred, mismatch, locked, err_evt, sat_hit, take;
  pa_state_e st;

  prbs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  assign take     = ana_en_i & rx_vld_i;
  assign mismatch = rx_bit_i ^ pred;
  assign locked   = (st == PA_LOCK);
  assign err_evt  = take & locked & mismatch;

  prbs_ref_gen #(.LFSR_W(LFSR_W), .TAP_A(TAP_A), .TAP_B(LFSR_W)) u_ref (
    .clk(clk), .rst_n(rst_ns), .shift_en(take),
    .load_sel(st == PA_HUNT), .bit_in(rx_bit_i), .pred_o(pred)
  );

  prbs_sync_ctl #(.LOAD_LEN(LFSR_W), .CONF_LEN(CONF_LEN)) u_ctl (
    .clk(clk), .rst_n(rst_ns), .en(ana_en_i), .bit_vld(rx_vld_i),
    .mismatch(mismatch), .sat_drop(sat_hit), .state_o(st)
  );

  prbs_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ns), .err_evt(err_evt), .rd_clr(rd_clr_i),
    .cnt_o(err_cnt_o), .sat_hit_o(sat_hit)
  );

  assign sync_lost_o = &err_cnt_o;
endmodule

// File: rtl/prbs_analyser_chk.sv
module prbs_analyser_chk
  import prbs_ana_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             ana_en_i,
  input logic             rd_clr_i,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             sync_lost_o,
  input pa_state_e        st
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ana_en_i && !rd_clr_i) |=> $stable(err_cnt_o)); // R2
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_clr_i |=> (err_cnt_o == $past(err_cnt_o) || err_cnt_o == $past(err_cnt_o) + 1'b1)); // R3
  AST_NO_COUNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_ns)
    (st != PA_LOCK && !rd_clr_i) |=> $stable(err_cnt_o)); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_clr_i |=> (err_cnt_o <= CNT_W'(1))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ns)
    (sync_lost_o && !rd_clr_i) |=> sync_lost_o); // R6
  AST_DROP_ON_SAT: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(sync_lost_o) |-> (st == PA_HUNT)); // R8
  AST_OFF_HUNT: assert property (@(posedge clk) disable iff (!rst_ns)
    !ana_en_i |=> (st == PA_HUNT)); // R9
endmodule

bind prbs_analyser prbs_analyser_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .ana_en_i(ana_en_i), .rd_clr_i(rd_clr_i),
  .err_cnt_o(err_cnt_o), .sync_lost_o(sync_lost_o), .st(st)
);

// File: tb/prbs_analyser_bench.sv
`timescale 1ns/1ps
module prbs_analyser_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ana_en_i = 1'b0, rx_bit_i = 1'b0, rx_vld_i = 1'b0, rd_clr_i = 1'b0;
  logic [7:0] err_cnt_o;
  logic       sync_lost_o;

  always #2 clk = ~clk;

  prbs_analyser u_prbs_analyser (
    .clk(clk), .rst_n(rst_n), .ana_en_i(ana_en_i), .rx_bit_i(rx_bit_i),
    .rx_vld_i(rx_vld_i), .rd_clr_i(rd_clr_i),
    .err_cnt_o(err_cnt_o), .sync_lost_o(sync_lost_o)
  );

  typedef struct { logic [7:0] cnt; string req; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;

  // expectation model built from the requirements
  int         m_ph = 0, m_idx = 0;
  logic [7:0] m_cnt = 8'h00;
  logic [14:0] gen = 15'h1ACE;

  function automatic logic next_prbs();
    logic b;
    b   = gen[13] ^ gen[14]; // R10: taps 14 and 15 back
    gen = {gen[13:0], b};
    return b;
  endfunction

  task automatic check(logic [7:0] exp, string req);
    n_chk++;
    if (err_cnt_o !== exp || sync_lost_o !== (exp == 8'hFF)) begin
      n_fail++;
      $display("FAIL %s: cnt=%02h lost=%b expected cnt=%02h lost=%b",
               req, err_cnt_o, sync_lost_o, exp, (exp == 8'hFF));
    end
  endtask

  task automatic drive(bit en, bit vld, bit err, bit rd, string req);
    logic [7:0] base;
    exp_t e;
    @(negedge clk);
    ana_en_i = en; rx_vld_i = vld; rd_clr_i = rd;
    rx_bit_i = vld ? (next_prbs() ^ err) : ~gen[0];
    base = rd ? 8'h00 : m_cnt;
    if (!en) begin
      m_ph = 0; m_idx = 0;
    end else if (vld) begin
      case (m_ph)
        0: if (m_idx == 14) begin m_ph = 1; m_idx = 0; end else m_idx++;
        1: if (err) begin m_ph = 0; m_idx = 0; end
           else if (m_idx == 15) begin m_ph = 2; m_idx = 0; end
           else m_idx++;
        default: if (err) begin
          if (base != 8'hFF) base = base + 8'd1;
          if (base == 8'hFF) begin m_ph = 0; m_idx = 0; end
        end
      endcase
    end
    m_cnt = base;
    e.cnt = m_cnt; e.req = req;
    q.push_back(e);
  endtask

  task automatic clean(int n, string req);
    for (int i = 0; i < n; i++) drive(1, 1, 0, 0, req);
  endtask

  // monitor: one expectation per clock edge after it is pushed
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.cnt, e.req);
    end
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(8'h00, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(8'h00, "R1");

    // R4: mismatch inside the confirmation run restarts acquisition
    clean(20, "R4");
    drive(1, 1, 1, 0, "R4");
    clean(31, "R4");
    // R3: counted errors, invalid cycles ignored
    drive(1, 1, 1, 0, "R3");
    drive(1, 0, 1, 0, "R3");
    drive(1, 1, 1, 0, "R3");
    drive(1, 0, 0, 0, "R3");
    clean(5, "R3");
    drive(1, 1, 1, 0, "R3");
    // R5 read clears, R7 read with error gives 1
    drive(1, 0, 0, 1, "R5");
    drive(1, 1, 1, 1, "R7");
    drive(1, 1, 1, 0, "R3");
    // R2: disabled, errors not counted
    for (int i = 0; i < 5; i++) drive(0, 1, 1, 0, "R2");
    // R9: lock not kept across disable
    clean(15, "R9");
    drive(1, 1, 1, 0, "R9");
    clean(31, "R9");
    drive(1, 1, 1, 0, "R9");
    // R6/R8 saturation
    drive(1, 0, 0, 1, "R5");
    for (int i = 0; i < 255; i++) drive(1, 1, 1, 0, "R6");
    clean(40, "R6");
    drive(1, 1, 1, 0, "R6");
    clean(31, "R8");
    drive(1, 0, 0, 1, "R5");
    drive(1, 1, 1, 0, "R8");
    drive(1, 0, 0, 0, "R3");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule